// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

The block turns data words into a bit stream on one data line and marks the start of each frame with an active-high sync pulse. A set of frame-shape inputs selects the word length (2 to 32 bits), which end of the word leaves first, the line level between frames, how many words one frame carries, and how long the sync pulse lasts (1 to 16 periods). During the sync pulse the line can optionally carry bits from a separate sync pattern. All sequencing advances only on cycles where the transmit clock enable `tick` is high.

Software, or a feeding block, places each word in a single holding register through a ready/write handshake. One start request sends one complete frame. The frame is the sync pulse followed at once by the words, with no gap between them. If the next word is due and the holding register is empty, the frame stops, the line returns to its idle level and a sticky underrun flag is raised. A size code tells the feeder how wide its writes to the holding register should be.

Top module: `fsync_tx`

## Requirements
- R1: A word carries `cfg_wlen_m1`+1 bits; a start request while `cfg_wlen_m1` is 0 is refused and no frame begins (`busy` stays low).
- R2: With `cfg_msb_first`=1 the highest used bit (bit `cfg_wlen_m1`) of a word leaves first; with 0, bit 0 leaves first.
- R3: Whenever `busy` is low, including after reset, `txd` equals `cfg_idle_lvl`.
- R4: A frame carries `cfg_words_m1`+1 words sent back to back, the first word starting in the period right after the last sync period; after the last bit `busy` drops.
- R5: `fsync` is high for exactly `cfg_sync_len_m1`+1 tick periods, starting with the period that begins at the tick edge which accepts the start.
- R6: With `cfg_sync_en`=1, `txd` in sync period k carries bit k of `sync_pattern` (bit 0 first); with 0 it carries `cfg_idle_lvl`.
- R7: `hold_size` is 0 (byte) for `cfg_wlen_m1` up to 7, 1 (half-word) for 8 to 15, and 2 (full word) for 16 and above.
- R8: `hold_ready` is high exactly when the holding register is empty; `hold_wr` while ready stores `hold_data` and drops `hold_ready`; a word is removed when it starts to be sent.
- R9: If the holding register is empty when a word is due, the frame ends at that tick, `txd` returns to the idle level and `underrun` is set; it stays set until `clr_underrun` is pulsed.
- R10: A start request while a frame is running is ignored and does not alter that frame.
- R11: After reset `busy`, `fsync` and `underrun` are low and `hold_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Transmit clock enable, one bit period per high cycle |
| start | input | 1 | Frame start request, taken on a tick cycle |
| cfg_wlen_m1 | input | LEN_W (5) | Word length minus one |
| cfg_msb_first | input | 1 | 1: high bit first, 0: bit 0 first |
| cfg_idle_lvl | input | 1 | Line level outside a frame |
| cfg_words_m1 | input | NUM_W (4) | Words per frame minus one |
| cfg_sync_len_m1 | input | SLEN_W (4) | Sync pulse length minus one |
| cfg_sync_en | input | 1 | Send pattern bits during the sync pulse |
| sync_pattern | input | SYNC_W (16) | Bits sent during the sync pulse |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | WORD_W (32) | Word written to the holding register |
| hold_ready | output | 1 | Holding register is empty |
| hold_size | output | 2 | Write size code: 0 byte, 1 half-word, 2 word |
| clr_underrun | input | 1 | Clears the underrun flag |
| txd | output | 1 | Serial data line |
| fsync | output | 1 | Frame sync pulse, active high |
| busy | output | 1 | A frame is in progress |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 16-bit sync pattern and 4-bit length and word-count fields. This puts every legal word length from 2 to 32 bits, all three holding-register size codes, sync pulses from 1 to 16 periods and frames of up to 16 words in reach. Random frames mix these settings, and directed frames cover the shortest and longest pulse and word, a refused 1-bit length, a start during a frame, and a starved holding register.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } fstx_state_e;

  // Holding-register access size from the word length field.
  function automatic logic [1:0] size_code(input logic [7:0] wlen_m1);
    if (wlen_m1 <= 8'd7)       return 2'd0;
    else if (wlen_m1 <= 8'd15) return 2'd1;
    else                       return 2'd2;
  endfunction

  // Position inside the word of the k-th transmitted bit.
  function automatic logic [7:0] bit_index(input logic [7:0] wlen_m1,
                                           input logic       msb_first,
                                           input logic [7:0] k);
    return msb_first ? (wlen_m1 - k) : k;
  endfunction

endpackage

// File: rtl/fstx_hold.sv
module fstx_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr && !full) begin
      full <= 1'b1;
      word <= wdata;
    end
  end

endmodule

// File: rtl/fstx_seq.sv
module fstx_seq
  import fstx_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int SLEN_W = 4,
  parameter int NUM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [LEN_W-1:0]  wlen_m1,
  input  logic [NUM_W-1:0]  words_m1,
  input  logic [SLEN_W-1:0] slen_m1,
  input  logic              hold_full,
  input  logic              clr_underrun,
  output fstx_state_e       state,
  output logic [LEN_W-1:0]  wlen_q,
  output logic [LEN_W-1:0]  bit_cnt,
  output logic [SLEN_W-1:0] sync_cnt,
  output logic              start_ok,
  output logic              take,
  output logic              starve,
  output logic              underrun
);

  logic [NUM_W-1:0]  words_q;
  logic [SLEN_W-1:0] slen_q;
  logic [NUM_W-1:0]  word_cnt;
  logic sync_last, bit_last, last_word, word_due;

  assign start_ok  = tick && start && (state == ST_IDLE) && (wlen_m1 != '0);
  assign sync_last = (state == ST_SYNC) && (sync_cnt == slen_q);
  assign bit_last  = (state == ST_DATA) && (bit_cnt == wlen_q);
  assign last_word = (word_cnt == words_q);
  assign word_due  = tick && (sync_last || (bit_last && !last_word));
  assign take      = word_due && hold_full;
  assign starve    = word_due && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wlen_q   <= '0;
      words_q  <= '0;
      slen_q   <= '0;
      bit_cnt  <= '0;
      sync_cnt <= '0;
      word_cnt <= '0;
    end else if (start_ok) begin
      state    <= ST_SYNC;
      wlen_q   <= wlen_m1;
      words_q  <= words_m1;
      slen_q   <= slen_m1;
      sync_cnt <= '0;
    end else if (tick) begin
      unique case (state)
        ST_SYNC: begin
          if (!sync_last)  sync_cnt <= sync_cnt + 1'b1;
          else if (take) begin
            state    <= ST_DATA;
            bit_cnt  <= '0;
            word_cnt <= '0;
          end else       state <= ST_IDLE;
        end
        ST_DATA: begin
          if (!bit_last)      bit_cnt <= bit_cnt + 1'b1;
          else if (last_word) state   <= ST_IDLE;
          else if (take) begin
            bit_cnt  <= '0;
            word_cnt <= word_cnt + 1'b1;
          end else            state   <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (starve)       underrun <= 1'b1;
    else if (clr_underrun) underrun <= 1'b0;
  end

endmodule

// File: rtl/fstx_outsel.sv
module fstx_outsel
  import fstx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SYNC_W = 16,
  parameter int LEN_W  = 5,
  parameter int SLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              take,
  input  logic              msb_first,
  input  logic              sync_en,
  input  logic              idle_lvl,
  input  logic [SYNC_W-1:0] pattern,
  input  logic [WORD_W-1:0] hold_word,
  input  fstx_state_e       state,
  input  logic [LEN_W-1:0]  wlen_q,
  input  logic [LEN_W-1:0]  bit_cnt,
  input  logic [SLEN_W-1:0] sync_cnt,
  output logic              txd
);

  logic              msb_q, sen_q;
  logic [SYNC_W-1:0] pat_q;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q  <= 1'b0;
      sen_q  <= 1'b0;
      pat_q  <= '0;
      word_q <= '0;
    end else begin
      if (start_ok) begin
        msb_q <= msb_first;
        sen_q <= sync_en;
        pat_q <= pattern;
      end
      if (take) word_q <= hold_word;
    end
  end

  assign idx = bit_index(8'(wlen_q), msb_q, 8'(bit_cnt));

  always_comb begin
    unique case (state)
      ST_SYNC: txd = sen_q ? pat_q[sync_cnt] : idle_lvl;
      ST_DATA: txd = word_q[idx[LEN_W-1:0]];
      default: txd = idle_lvl;
    endcase
  end

endmodule

// File: rtl/fsync_tx.sv
module fsync_tx
  import fstx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SYNC_W = 16,
  parameter int NUM_W  = 4,
  parameter int LEN_W  = $clog2(WORD_W),
  parameter int SLEN_W = $clog2(SYNC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_wlen_m1,
  input  logic              cfg_msb_first,
  input  logic              cfg_idle_lvl,
  input  logic [NUM_W-1:0]  cfg_words_m1,
  input  logic [SLEN_W-1:0] cfg_sync_len_m1,
  input  logic              cfg_sync_en,
  input  logic [SYNC_W-1:0] sync_pattern,
  input  logic              hold_wr,
  input  logic [WORD_W-1:0] hold_data,
  output logic              hold_ready,
  output logic [1:0]        hold_size,
  input  logic              clr_underrun,
  output logic              txd,
  output logic              fsync,
  output logic              busy,
  output logic              underrun
);

  fstx_state_e       state;
  logic              hold_full, start_ok, word_take, word_starve;
  logic [WORD_W-1:0] hold_word;
  logic [LEN_W-1:0]  wlen_q, bit_cnt;
  logic [SLEN_W-1:0] sync_cnt;

  fstx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(hold_wr), .wdata(hold_data),
    .take(word_take), .full(hold_full), .word(hold_word)
  );

  fstx_seq #(.LEN_W(LEN_W), .SLEN_W(SLEN_W), .NUM_W(NUM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .wlen_m1(cfg_wlen_m1), .words_m1(cfg_words_m1), .slen_m1(cfg_sync_len_m1),
    .hold_full(hold_full), .clr_underrun(clr_underrun),
    .state(state), .wlen_q(wlen_q), .bit_cnt(bit_cnt), .sync_cnt(sync_cnt),
    .start_ok(start_ok), .take(word_take), .starve(word_starve),
    .underrun(underrun)
  );

  fstx_outsel #(.WORD_W(WORD_W), .SYNC_W(SYNC_W), .LEN_W(LEN_W), .SLEN_W(SLEN_W)) u_out (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .take(word_take),
    .msb_first(cfg_msb_first), .sync_en(cfg_sync_en), .idle_lvl(cfg_idle_lvl),
    .pattern(sync_pattern), .hold_word(hold_word), .state(state),
    .wlen_q(wlen_q), .bit_cnt(bit_cnt), .sync_cnt(sync_cnt), .txd(txd)
  );

  assign hold_ready = !hold_full;
  assign hold_size  = size_code(8'(cfg_wlen_m1));
  assign fsync      = (state == ST_SYNC);
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/fstx_chk.sv
module fstx_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             start,
  input logic [LEN_W-1:0] cfg_wlen_m1,
  input logic             cfg_idle_lvl,
  input logic             clr_underrun,
  input logic             hold_wr,
  input logic             hold_ready,
  input logic [1:0]       hold_size,
  input logic             txd,
  input logic             fsync,
  input logic             busy,
  input logic             underrun,
  input logic             word_take,
  input logic             word_starve
);

  p_reject_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && start && !busy && cfg_wlen_m1 == '0) |=> !busy);

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd == cfg_idle_lvl));

  p_sync_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> busy);

  p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_size != 2'd3);

  p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr && hold_ready) |=> !hold_ready);

  p_take_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> !hold_ready);

  p_starve_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_starve |=> (underrun && !busy));

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_underrun) |=> underrun);

endmodule

bind fsync_tx fstx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
  .cfg_wlen_m1(cfg_wlen_m1), .cfg_idle_lvl(cfg_idle_lvl),
  .clr_underrun(clr_underrun), .hold_wr(hold_wr), .hold_ready(hold_ready),
  .hold_size(hold_size), .txd(txd), .fsync(fsync), .busy(busy),
  .underrun(underrun), .word_take(word_take), .word_starve(word_starve)
);

// File: tb/test_fsync_tx.sv
module test_fsync_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, start = 1'b0;
  logic [4:0]  cfg_wlen_m1 = 5'd7;
  logic        cfg_msb_first = 1'b0, cfg_idle_lvl = 1'b1;
  logic [3:0]  cfg_words_m1 = '0, cfg_sync_len_m1 = '0;
  logic        cfg_sync_en = 1'b0;
  logic [15:0] sync_pattern = '0;
  logic        hold_wr = 1'b0;
  logic [31:0] hold_data = '0;
  logic        hold_ready;
  logic [1:0]  hold_size;
  logic        clr_underrun = 1'b0;
  logic        txd, fsync, busy, underrun;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] feedq [16];
  int feed_idx = 0, feed_lim = 0;

  always #5ns clk = ~clk;

  fsync_tx i_fsync_tx (.*);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_size(input int wl);
    return (wl < 8) ? 2'd0 : (wl < 16) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic exp_data(input logic [31:0] w, input int wl,
                                    input logic msb, input int k);
    logic [31:0] s;
    s = msb ? (w >> (wl - k)) : (w >> k);
    return s[0];
  endfunction

  // One tick period: tick edge, sample after it, optional feed write.
  task automatic period(input logic st, output logic fs, output logic td);
    @(negedge clk); tick = 1'b1; start = st; hold_wr = 1'b0;
    @(negedge clk); tick = 1'b0; start = 1'b0;
    fs = fsync; td = txd;
    if (hold_ready && feed_idx < feed_lim) begin
      hold_wr = 1'b1; hold_data = feedq[feed_idx]; feed_idx++;
    end
  endtask

  task automatic preload(input logic [31:0] w);
    @(negedge clk); hold_wr = 1'b1; hold_data = w;
    @(negedge clk); hold_wr = 1'b0;
  endtask

  // Send one frame and compare every period. supply: words offered.
  task automatic run_frame(input int wl, input int nw, input int sl,
                           input logic msb, input logic sen, input logic idle,
                           input logic [15:0] pat, input int supply,
                           input int mid_start);
    int total, got;
    logic fs, td, efs, etd;
    cfg_wlen_m1 = 5'(wl); cfg_words_m1 = 4'(nw); cfg_sync_len_m1 = 4'(sl);
    cfg_msb_first = msb; cfg_sync_en = sen; cfg_idle_lvl = idle;
    sync_pattern = pat;
    for (int i = 0; i < 16; i++) feedq[i] = $urandom;
    preload(feedq[0]);
    feed_idx = 1; feed_lim = supply;
    got = (supply < nw + 1) ? supply : nw + 1;
    total = sl + 1 + got * (wl + 1);
    for (int p = 0; p < total; p++) begin
      period(p == 0 || p == mid_start, fs, td);
      if (p <= sl) begin
        efs = 1'b1;
        etd = sen ? pat[p] : idle;
        check("R5", "fsync in sync period", 32'(fs), 32'(efs));
        check("R6", "txd in sync period", 32'(td), 32'(etd));
      end else begin
        int q = p - sl - 1;
        efs = 1'b0;
        etd = exp_data(feedq[q / (wl + 1)], wl, msb, q % (wl + 1));
        check("R4", "fsync in data period", 32'(fs), 32'(efs));
        check("R2", "txd data bit", 32'(td), 32'(etd));
      end
    end
    period(1'b0, fs, td);
    hold_wr = 1'b0;
    check("R4", "busy after frame", 32'(busy), 32'(0));
    check("R3", "txd idle after frame", 32'(td), 32'(idle));
    check("R8", "ready after frame", 32'(hold_ready), 32'(1));
  endtask

  initial begin
    #(2_000_000ns);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic fs, td;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "busy at reset", 32'(busy), 32'(0));
    check("R11", "fsync at reset", 32'(fsync), 32'(0));
    check("R11", "underrun at reset", 32'(underrun), 32'(0));
    check("R11", "ready at reset", 32'(hold_ready), 32'(1));
    check("R3", "txd idle at reset", 32'(txd), 32'(1));
    cfg_idle_lvl = 1'b0; @(negedge clk);
    check("R3", "txd follows idle level", 32'(txd), 32'(0));

    for (int w = 0; w < 32; w++) begin
      cfg_wlen_m1 = 5'(w); #1ns;
      check("R7", "hold size code", 32'(hold_size), 32'(exp_size(w)));
    end

    // R1: 1-bit words refused
    cfg_wlen_m1 = 5'd0;
    period(1'b1, fs, td);
    check("R1", "busy after illegal length", 32'(busy), 32'(0));
    check("R1", "fsync after illegal length", 32'(fs), 32'(0));

    // R8 handshake
    preload(32'hA5);
    check("R8", "ready after write", 32'(hold_ready), 32'(0));
    // directed frames (word already held is replaced by run_frame preload? no: drain)
    cfg_wlen_m1 = 5'd7; cfg_words_m1 = '0; cfg_sync_len_m1 = '0; cfg_sync_en = 1'b0;
    for (int p = 0; p < 10; p++) period(p == 0, fs, td);
    check("R8", "ready after drain", 32'(hold_ready), 32'(1));

    // R1 shortest word, R5 shortest pulse, R2 both orders
    run_frame(1, 2, 0, 1'b0, 1'b1, 1'b1, 16'h0001, 3, -1);
    run_frame(1, 0, 0, 1'b1, 1'b0, 1'b0, 16'h0000, 1, -1);
    // longest word and pulse with pattern
    run_frame(31, 1, 15, 1'b1, 1'b1, 1'b0, 16'hB38D, 2, -1);
    run_frame(31, 0, 15, 1'b0, 1'b1, 1'b1, 16'h4C72, 1, -1);
    // R10: start during frame ignored
    run_frame(9, 2, 3, 1'b1, 1'b1, 1'b0, 16'h00F5, 3, 6);
    run_frame(12, 1, 2, 1'b0, 1'b0, 1'b1, 16'h0000, 2, 20);
    // R9: only two of four words supplied
    run_frame(7, 3, 1, 1'b0, 1'b1, 1'b1, 16'h0002, 2, -1);
    check("R9", "underrun set", 32'(underrun), 32'(1));
    period(1'b0, fs, td);
    check("R9", "underrun stays set", 32'(underrun), 32'(1));
    @(negedge clk); clr_underrun = 1'b1;
    @(negedge clk); clr_underrun = 1'b0;
    check("R9", "underrun cleared", 32'(underrun), 32'(0));

    for (int f = 0; f < 24; f++) begin
      int wl = $urandom_range(31, 1);
      int nw = $urandom_range(3, 0);
      run_frame(wl, nw, $urandom_range(15, 0), 1'($urandom), 1'($urandom),
                1'($urandom), 16'($urandom), nw + 1, -1);
    end
    check("R9", "no underrun on fed frames", 32'(underrun), 32'(0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule